// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This block decides whether a branch instruction is taken and produces every side effect that follows from that decision. One request carries the branch form, a five-bit option code, a five-bit bit selector, the 32-bit condition register, the count register, the link register, a precomputed immediate target and the address of the branch. On the next clock the block presents the taken flag, the selected target address, the write to the count register and the write to the link register. Each write has its own enable. An error flag marks an illegal combination.

The option code combines three kinds of test. It can test one condition-register bit for either polarity. It can decrement the count register and test the new value for zero or non-zero. It can do both, or neither. Some of its bits are don't-care bits, and one bit is a prediction hint that plays no part in the decision. The link register write carries the address of the next instruction, and it happens whether or not the branch is taken. The surrounding pipeline applies the writes and redirects fetch. Fetch, decode, prediction and flushing are outside this block.

Top module: `bcu_top`

## Requirements
- R1: While reset is held, and in the cycle after a clock edge where `req_vld` was low, every output is 0.
- R2: Results appear in the cycle after the clock edge that samples `req_vld` high, with `res_vld` high.
- R3: `bi` selects condition bit `cr[31-bi]`, so `bi`=0 selects the MSB.
- R4: Option codes 001zy take the branch when the selected bit is 0. Option codes 011zy take it when the bit is 1. Neither touches the count register.
- R5: Option codes 0s0ny (s = required bit value, n = 0 for a non-zero test, 1 for a zero test) decrement the count register. They take the branch when the new count passes the zero test and the selected bit equals s.
- R6: Option codes 1z0ny decrement the count register and take the branch on the zero test alone. The condition bit is not consulted.
- R7: Option codes 1z1zz always take the branch with no decrement. The unconditional form (`form`=0) always takes the branch, ignores `bo` entirely and never writes the count register.
- R8: The z bits and the hint bit y have no effect on any output.
- R9: `ctr_we` is high exactly when a valid conditional request's option code has bit 2 clear, and `ctr_wdata` = `ctr_in` - 1 modulo 2^32 (0 becomes 0xFFFFFFFF).
- R10: The target is `imm_tgt` for forms 0 and 1 (immediate), `lr_in` with bits 1:0 cleared for form 2, and `ctr_in` with bits 1:0 cleared for form 3. Form 2 uses the old `lr_in` even when a link is requested.
- R11: When `link_req` is set on a legal request, `lr_we` is high with `lr_wdata` = `pc` + 4, whether or not the branch is taken.
- R12: Form 3 with a decrementing option code (bit 2 clear) raises `bad_form` and forces `taken`, `ctr_we` and `lr_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| form | input | 2 | 0 unconditional immediate, 1 conditional immediate, 2 conditional to link, 3 conditional to count |
| link_req | input | 1 | Write the next-instruction address to the link register |
| bo | input | 5 | Option code (bit 4 is the first bit) |
| bi | input | 5 | Condition bit selector |
| cr | input | 32 | Condition register |
| ctr_in | input | 32 | Current count register |
| lr_in | input | 32 | Current link register |
| imm_tgt | input | 32 | Precomputed immediate target |
| pc | input | 32 | Address of the branch |
| res_vld | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| target | output | 32 | Selected target address |
| ctr_we | output | 1 | Count register write enable |
| ctr_wdata | output | 32 | New count value |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | 32 | New link value |
| bad_form | output | 1 | Illegal decrement in the to-count form |

## Verification
The assertions check on every cycle the rules that tie a result to the request one cycle earlier. An idle cycle leaves the outputs clear. A count write always carries the old count minus one, and a link write always carries the branch address plus four. The illegal form suppresses every side effect. Branch-always and unconditional requests are taken, and a legal link request always writes. The bench scenarios show the full decision table, including the polarity of the condition test, the zero and non-zero tests at the wrap boundary, the bit numbering of the selector, the insensitivity to the don't-care and hint bits, and the target chosen in each form.

// File: rtl/bcu_pkg.sv
// Shared types for the branch condition evaluation unit.
// Assumes option code bit 4 is the first (most significant) bit.
package bcu_pkg;

    typedef enum logic [1:0] {
        FORM_UNC = 2'd0,   // unconditional, immediate target
        FORM_IMM = 2'd1,   // conditional, immediate target
        FORM_LR  = 2'd2,   // conditional, target from link register
        FORM_CTR = 2'd3    // conditional, target from count register
    } bform_e;

    // Decoded option-code controls
    typedef struct packed {
        logic dec;         // decrement the count register
        logic use_cond;    // consult the condition bit
        logic cond_sense;  // required value of the condition bit
        logic want_zero;   // count test: 1 = new count zero, 0 = non-zero
        logic always_tk;   // branch always
    } bo_ctl_t;

endpackage

// File: rtl/bcu_bo_decode.sv
// Decodes the five-bit option code into independent test controls.
// Don't-care bits and the hint bit (bit 0) are never read.
module bcu_bo_decode
    import bcu_pkg::*;
(
    input  logic [4:0] bo,
    output bo_ctl_t    ctl
);

    // Split the option code into its count, condition and always parts
    always_comb begin
        ctl.dec        = ~bo[2];
        ctl.use_cond   = ~bo[4];
        ctl.cond_sense = bo[3];
        ctl.want_zero  = bo[1];
        ctl.always_tk  = bo[4] & bo[2];
    end

endmodule

// File: rtl/bcu_cond_eval.sv
// Evaluates the condition-bit test and the decremented-count test.
// Assumes bit selector 0 addresses the MSB of the condition register.
module bcu_cond_eval
    import bcu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CRW  = 32,
    localparam int BIW = $clog2(CRW)
) (
    input  bo_ctl_t           ctl,
    input  logic [BIW-1:0]    bi,
    input  logic [CRW-1:0]    cr,
    input  logic [XLEN-1:0]   ctr,
    output logic [XLEN-1:0]   ctr_dec,
    output logic              cond_met,
    output logic              ctr_met
);

    logic [CRW-1:0] cr_rev;
    logic           cr_bit;
    logic           dec_zero;

    // Reverse the condition register so the selector indexes from the MSB
    for (genvar i = 0; i < CRW; i++) begin : g_rev
        assign cr_rev[i] = cr[CRW-1-i];
    end

    // Select the bit, decrement the count and form both test results
    always_comb begin
        cr_bit   = cr_rev[bi];
        ctr_dec  = ctr - XLEN'(1);
        dec_zero = (ctr_dec == '0);
        cond_met = ~ctl.use_cond | (cr_bit == ctl.cond_sense);
        ctr_met  = ~ctl.dec | (dec_zero == ctl.want_zero);
    end

endmodule

// File: rtl/bcu_target_sel.sv
// Chooses the branch target per form and forms the next-instruction address.
// Register-sourced targets have their two low bits cleared.
module bcu_target_sel
    import bcu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int ISTEP = 4
) (
    input  bform_e            form,
    input  logic [XLEN-1:0]   imm_tgt,
    input  logic [XLEN-1:0]   lr_in,
    input  logic [XLEN-1:0]   ctr_in,
    input  logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   target,
    output logic [XLEN-1:0]   next_pc
);

    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(ISTEP - 1);

    // Pick the target source and compute the return address
    always_comb begin
        unique case (form)
            FORM_LR:  target = lr_in & ALIGN_MASK;
            FORM_CTR: target = ctr_in & ALIGN_MASK;
            default:  target = imm_tgt;
        endcase
        next_pc = pc + XLEN'(ISTEP);
    end

endmodule

// File: rtl/bcu_top.sv
// Branch condition evaluation unit: one request in, registered result one
// cycle later. Assumes the caller applies the count and link writes.
module bcu_top
    import bcu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CRW  = 32,
    localparam int BIW = $clog2(CRW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [1:0]       form,
    input  logic             link_req,
    input  logic [4:0]       bo,
    input  logic [BIW-1:0]   bi,
    input  logic [CRW-1:0]   cr,
    input  logic [XLEN-1:0]  ctr_in,
    input  logic [XLEN-1:0]  lr_in,
    input  logic [XLEN-1:0]  imm_tgt,
    input  logic [XLEN-1:0]  pc,
    output logic             res_vld,
    output logic             taken,
    output logic [XLEN-1:0]  target,
    output logic             ctr_we,
    output logic [XLEN-1:0]  ctr_wdata,
    output logic             lr_we,
    output logic [XLEN-1:0]  lr_wdata,
    output logic             bad_form
);

    bform_e          form_e;
    bo_ctl_t         ctl;
    logic [XLEN-1:0] ctr_dec;
    logic            cond_met;
    logic            ctr_met;
    logic [XLEN-1:0] tgt_d;
    logic [XLEN-1:0] next_pc;
    logic            bad_d;
    logic            taken_d;
    logic            ctr_we_d;
    logic            lr_we_d;

    assign form_e = bform_e'(form);

    bcu_bo_decode u_dec (
        .bo  (bo),
        .ctl (ctl)
    );

    bcu_cond_eval #(.XLEN(XLEN), .CRW(CRW)) u_eval (
        .ctl      (ctl),
        .bi       (bi),
        .cr       (cr),
        .ctr      (ctr_in),
        .ctr_dec  (ctr_dec),
        .cond_met (cond_met),
        .ctr_met  (ctr_met)
    );

    bcu_target_sel #(.XLEN(XLEN)) u_tgt (
        .form    (form_e),
        .imm_tgt (imm_tgt),
        .lr_in   (lr_in),
        .ctr_in  (ctr_in),
        .pc      (pc),
        .target  (tgt_d),
        .next_pc (next_pc)
    );

    // Combine form, decoded tests and legality into the next-cycle result
    always_comb begin
        bad_d    = req_vld && (form_e == FORM_CTR) && ctl.dec;
        if (form_e == FORM_UNC) begin
            taken_d  = 1'b1;
            ctr_we_d = 1'b0;
        end else begin
            taken_d  = ctl.always_tk | (cond_met & ctr_met);
            ctr_we_d = ctl.dec;
        end
        taken_d  = req_vld && !bad_d && taken_d;
        ctr_we_d = req_vld && !bad_d && ctr_we_d;
        lr_we_d  = req_vld && !bad_d && link_req;
    end

    // Register the result; idle cycles clear every output
    always_ff @(posedge clk) begin
        if (!rst_n || !req_vld) begin
            res_vld   <= 1'b0;
            taken     <= 1'b0;
            target    <= '0;
            ctr_we    <= 1'b0;
            ctr_wdata <= '0;
            lr_we     <= 1'b0;
            lr_wdata  <= '0;
            bad_form  <= 1'b0;
        end else begin
            res_vld   <= 1'b1;
            taken     <= taken_d;
            target    <= tgt_d;
            ctr_we    <= ctr_we_d;
            ctr_wdata <= ctr_dec;
            lr_we     <= lr_we_d;
            lr_wdata  <= next_pc;
            bad_form  <= bad_d;
        end
    end

endmodule

// File: rtl/bcu_chk.sv
// Property checker for bcu_top, attached by bind below.
module bcu_chk #(
    parameter int XLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic [1:0]       form,
    input logic             link_req,
    input logic [4:0]       bo,
    input logic [XLEN-1:0]  ctr_in,
    input logic [XLEN-1:0]  pc,
    input logic             res_vld,
    input logic             taken,
    input logic             ctr_we,
    input logic [XLEN-1:0]  ctr_wdata,
    input logic             lr_we,
    input logic [XLEN-1:0]  lr_wdata,
    input logic             bad_form
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> !taken && !ctr_we && !lr_we && !bad_form);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);

    // R9
    ctr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_we |-> $past(req_vld) && ctr_wdata == $past(ctr_in) - XLEN'(1));

    // R11
    lr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> $past(req_vld) && lr_wdata == $past(pc) + XLEN'(4));

    // R11
    link_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && link_req && !(form == 2'd3 && !bo[2])) |=> lr_we);

    // R12
    bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> !taken && !ctr_we && !lr_we);

    // R7
    uncond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && form == 2'd0) |=> taken && !ctr_we);

    // R7
    always_tk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && bo[4] && bo[2]) |=> taken && !ctr_we && !bad_form);

endmodule

bind bcu_top bcu_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .form      (form),
    .link_req  (link_req),
    .bo        (bo),
    .ctr_in    (ctr_in),
    .pc        (pc),
    .res_vld   (res_vld),
    .taken     (taken),
    .ctr_we    (ctr_we),
    .ctr_wdata (ctr_wdata),
    .lr_we     (lr_we),
    .lr_wdata  (lr_wdata),
    .bad_form  (bad_form)
);

// File: tb/sim_bcu_top.sv
module sim_bcu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [1:0]  form = '0;
    logic        link_req = 1'b0;
    logic [4:0]  bo = '0;
    logic [4:0]  bi = '0;
    logic [31:0] cr = 32'hA000_0001;
    logic [31:0] ctr_in = '0;
    logic [31:0] lr_in = 32'h0000_3003;
    logic [31:0] imm_tgt = 32'h0000_2000;
    logic [31:0] pc = 32'h0000_1000;
    logic        res_vld, taken, ctr_we, lr_we, bad_form;
    logic [31:0] target, ctr_wdata, lr_wdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bcu_top u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .form(form),
        .link_req(link_req), .bo(bo), .bi(bi), .cr(cr), .ctr_in(ctr_in),
        .lr_in(lr_in), .imm_tgt(imm_tgt), .pc(pc), .res_vld(res_vld),
        .taken(taken), .target(target), .ctr_we(ctr_we),
        .ctr_wdata(ctr_wdata), .lr_we(lr_we), .lr_wdata(lr_wdata),
        .bad_form(bad_form)
    );

    // cr = A000_0001: bi0 -> 1, bi1 -> 0, bi2 -> 1, bi30 -> 0, bi31 -> 1 (R3)
    typedef struct packed {
        logic [1:0]  form;
        logic        link;
        logic [4:0]  bo;
        logic [4:0]  bi;
        logic [31:0] ctr;
        logic        e_taken;
        logic        e_ctr_we;
        logic        e_lr_we;
        logic        e_bad;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 5'b00000, 5'd0,  32'd5,      1'b1, 1'b0, 1'b1, 1'b0}, // R7 uncond ignores bo
        '{2'd1, 1'b0, 5'b00100, 5'd1,  32'd5,      1'b1, 1'b0, 1'b0, 1'b0}, // R4 false test, bit 0
        '{2'd1, 1'b0, 5'b00100, 5'd0,  32'd5,      1'b0, 1'b0, 1'b0, 1'b0}, // R4 false test, bit 1
        '{2'd1, 1'b0, 5'b01100, 5'd0,  32'd5,      1'b1, 1'b0, 1'b0, 1'b0}, // R4 true test
        '{2'd1, 1'b0, 5'b01100, 5'd1,  32'd5,      1'b0, 1'b0, 1'b0, 1'b0}, // R4 true test fails
        '{2'd1, 1'b0, 5'b01111, 5'd2,  32'd5,      1'b1, 1'b0, 1'b0, 1'b0}, // R8 z,y set
        '{2'd1, 1'b0, 5'b01000, 5'd0,  32'd5,      1'b1, 1'b1, 1'b0, 1'b0}, // R5 nz & true
        '{2'd1, 1'b0, 5'b01000, 5'd0,  32'd1,      1'b0, 1'b1, 1'b0, 1'b0}, // R5 reaches zero
        '{2'd1, 1'b0, 5'b01001, 5'd0,  32'd1,      1'b0, 1'b1, 1'b0, 1'b0}, // R8 hint set
        '{2'd1, 1'b0, 5'b01010, 5'd0,  32'd1,      1'b1, 1'b1, 1'b0, 1'b0}, // R5 zero & true
        '{2'd1, 1'b0, 5'b00000, 5'd1,  32'd3,      1'b1, 1'b1, 1'b0, 1'b0}, // R5 nz & false
        '{2'd1, 1'b0, 5'b00010, 5'd0,  32'd1,      1'b0, 1'b1, 1'b0, 1'b0}, // R5 zero & false, bit 1
        '{2'd1, 1'b0, 5'b10000, 5'd1,  32'd0,      1'b1, 1'b1, 1'b0, 1'b0}, // R6 R9 wrap to FFFFFFFF
        '{2'd1, 1'b0, 5'b11010, 5'd1,  32'd1,      1'b1, 1'b1, 1'b0, 1'b0}, // R6 zero, z set
        '{2'd1, 1'b0, 5'b10010, 5'd0,  32'd2,      1'b0, 1'b1, 1'b0, 1'b0}, // R6 zero test fails
        '{2'd2, 1'b1, 5'b10100, 5'd1,  32'd5,      1'b1, 1'b0, 1'b1, 1'b0}, // R7 R10 R11 to-LR
        '{2'd2, 1'b0, 5'b11111, 5'd1,  32'd5,      1'b1, 1'b0, 1'b0, 1'b0}, // R8 always, z set
        '{2'd3, 1'b0, 5'b10100, 5'd1,  32'h4006,   1'b1, 1'b0, 1'b0, 1'b0}, // R10 to-CTR
        '{2'd3, 1'b1, 5'b00000, 5'd1,  32'd5,      1'b0, 1'b0, 1'b0, 1'b1}, // R12 illegal
        '{2'd2, 1'b1, 5'b01100, 5'd30, 32'd5,      1'b0, 1'b0, 1'b1, 1'b0}  // R3 R11 not taken, link
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        req_vld  = 1'b1;
        form     = v.form;
        link_req = v.link;
        bo       = v.bo;
        bi       = v.bi;
        ctr_in   = v.ctr;
        @(posedge clk);
        #1;
        req_vld  = 1'b0;
    endtask

    logic [31:0] exp_tgt;

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 res_vld in reset", {31'd0, res_vld}, 32'd0);
        chk("R1 ctr_we in reset", {31'd0, ctr_we}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            apply(VEC[k]);
            chk("R2 res_vld", {31'd0, res_vld}, 32'd1);
            chk("R3..R8 taken", {31'd0, taken}, {31'd0, VEC[k].e_taken});
            chk("R9 ctr_we", {31'd0, ctr_we}, {31'd0, VEC[k].e_ctr_we});
            if (VEC[k].e_ctr_we)
                chk("R9 ctr_wdata", ctr_wdata, VEC[k].ctr - 32'd1);
            chk("R11 lr_we", {31'd0, lr_we}, {31'd0, VEC[k].e_lr_we});
            if (VEC[k].e_lr_we)
                chk("R11 lr_wdata", lr_wdata, pc + 32'd4);
            chk("R12 bad_form", {31'd0, bad_form}, {31'd0, VEC[k].e_bad});
            if (VEC[k].e_taken) begin
                case (VEC[k].form)
                    2'd2:    exp_tgt = lr_in & ~32'd3;
                    2'd3:    exp_tgt = VEC[k].ctr & ~32'd3;
                    default: exp_tgt = imm_tgt;
                endcase
                chk("R10 target", target, exp_tgt);
            end
        end
        // R1 idle cycle after a request clears outputs
        @(posedge clk);
        #1;
        chk("R1 idle res_vld", {31'd0, res_vld}, 32'd0);
        chk("R1 idle lr_we", {31'd0, lr_we}, 32'd0);
        // R9 wrap value written out explicitly
        apply('{2'd1, 1'b0, 5'b10000, 5'd0, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0});
        chk("R9 wrap data", ctr_wdata, 32'hFFFF_FFFF);
        // R10 to-LR target uses old LR while linking
        apply('{2'd2, 1'b1, 5'b10100, 5'd0, 32'd5, 1'b1, 1'b0, 1'b1, 1'b0});
        chk("R10 old LR target", target, 32'h0000_3000);
        // R1 reset during activity clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        req_vld = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 reset clears taken", {31'd0, taken}, 32'd0);
        req_vld = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule